// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the execute-stage arithmetic unit of a small 32-bit processor. From two register operands and a 4-bit function code it forms one of four results (sum, difference, bitwise AND, bitwise XOR). Alongside that result it keeps a three-bit flag register holding zero, negative and signed-overflow. Conditional branches downstream read these flags. The result is combinational. The flags are loaded on the rising clock edge only for an arithmetic/logical instruction, and only while the machine status reports normal operation.

A second, independent adder forms effective addresses (base plus displacement) and stack-pointer adjustments (plus or minus four). It never touches the flags. Operand fetch and result write-back belong to neighbouring stages.

Top module: `alu_ccr`

## Requirements
- R1: With `fn_code` = 0 (add), `alu_res` equals `op_b + op_a` modulo 2^32 in the same cycle.
- R2: With `fn_code` = 1 (subtract), `alu_res` equals `op_b - op_a` modulo 2^32. The first operand is subtracted from the second.
- R3: With `fn_code` = 2, `alu_res` is `op_a & op_b`; with `fn_code` = 3 it is `op_a ^ op_b`. A flag update from either code clears `flag_of`.
- R4: On a flag update, `flag_zf` becomes 1 exactly when `alu_res` was zero and `flag_sf` becomes bit 31 of `alu_res`. Both are visible after that rising edge.
- R5: On an add update, `flag_of` becomes 1 exactly when `op_a` and `op_b` share a sign bit and the result's sign bit differs from it.
- R6: On a subtract update, `flag_of` becomes 1 exactly when the operands' sign bits differ and the result's sign bit differs from that of `op_b`.
- R7: When `op_en` is 0 the three flags keep their values across the edge, whatever the other inputs are.
- R8: When `run_status` is not 1 (the normal-operation code), the flags keep their values even when `op_en` is 1.
- R9: While `rst_n` is low the flags read `flag_zf`=1, `flag_sf`=0, `flag_of`=0.
- R10: Function codes 4 to 15 drive `alu_res` to zero and leave the flags unchanged.
- R11: `addr_sum` equals `addr_base + addr_disp` modulo 2^32 in the same cycle (a displacement of 0xFFFFFFFC gives minus four). It has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_en | input | 1 | Current instruction is an arithmetic/logical op |
| fn_code | input | 4 | Operation select: 0 add, 1 sub, 2 and, 3 xor |
| op_a | input | 32 | First (source) register operand |
| op_b | input | 32 | Second (destination) register operand |
| run_status | input | 3 | Machine status; 1 means normal operation |
| alu_res | output | 32 | Operation result |
| addr_base | input | 32 | Address-path base value |
| addr_disp | input | 32 | Address-path displacement |
| addr_sum | output | 32 | Address-path sum |
| flag_zf | output | 1 | Registered zero flag |
| flag_sf | output | 1 | Registered sign flag |
| flag_of | output | 1 | Registered signed-overflow flag |

## Verification
`alu_res` and `addr_sum` are combinational, so the bench drives each operation on a falling edge and compares both one time unit later, in the same cycle. The flags pass through one register. They are compared at the next falling edge, after the rising edge that loads them. The bench's flag model is updated only when op_en, the status and the function code together allow a load, so the hold cases (R7, R8, R10) are checked against the previous flags at that same point.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

   localparam int FN_W = 4;

   localparam logic [FN_W-1:0] FN_ADD = 4'd0;
   localparam logic [FN_W-1:0] FN_SUB = 4'd1;
   localparam logic [FN_W-1:0] FN_AND = 4'd2;
   localparam logic [FN_W-1:0] FN_XOR = 4'd3;

   typedef struct packed {
      logic zf;
      logic sf;
      logic of;
   } cc_t;

   localparam cc_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
   parameter int DATA_W  = 32,
   parameter int CHUNK_W = 8
) (
   input  logic [DATA_W-1:0] val,
   output logic              is_zero
);
   localparam int N_CHUNK = DATA_W / CHUNK_W;

   if (CHUNK_W < 1 || (DATA_W % CHUNK_W) != 0) begin : g_bad_chunk
      $error("alu_zero_det: CHUNK_W must divide DATA_W");
   end

   logic [N_CHUNK-1:0] chunk_nz;

   for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
      assign chunk_nz[c] = |val[c*CHUNK_W +: CHUNK_W];
   end

   assign is_zero = ~|chunk_nz;
endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_ccr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [FN_W-1:0]   fn,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] res,
   output logic              ovf,
   output logic              fn_ok
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("alu_exec: DATA_W must be at least 2");
   end

   logic              is_sub;
   logic [DATA_W-1:0] opa_x;
   logic [DATA_W-1:0] sum;
   logic              sum_ovf;

   // one adder serves add and subtract: opb + (~opa) + 1 == opb - opa
   assign is_sub  = (fn == FN_SUB);
   assign opa_x   = is_sub ? ~opa : opa;
   assign sum     = opb + opa_x + {{(DATA_W-1){1'b0}}, is_sub};
   assign sum_ovf = (opb[MSB] == opa_x[MSB]) && (sum[MSB] != opb[MSB]);

   always_comb begin
      res   = '0;
      ovf   = 1'b0;
      fn_ok = 1'b1;
      case (fn)
         FN_ADD, FN_SUB: begin
            res = sum;
            ovf = sum_ovf;
         end
         FN_AND: res = opa & opb;
         FN_XOR: res = opa ^ opb;
         default: fn_ok = 1'b0;
      endcase
   end

   // R10: an unknown code must never produce a nonzero result
   always_comb begin
      if (!fn_ok) a_unknown_zero_r10: assert (res == '0);
   end
endmodule

// File: rtl/alu_addr_add.sv
module alu_addr_add #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] disp,
   output logic [DATA_W-1:0] sum
);
   assign sum = base + disp;
endmodule

// File: rtl/alu_cc_reg.sv
module alu_cc_reg
   import alu_ccr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  cc_t  nxt,
   output cc_t  cur
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur <= CC_RESET;
      else if (load) cur <= nxt;
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cur));
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
   import alu_ccr_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int STAT_W    = 3,
   parameter int ST_NORMAL = 1,
   parameter int ZD_CHUNK  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_en,
   input  logic [FN_W-1:0]   fn_code,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [STAT_W-1:0] run_status,
   output logic [DATA_W-1:0] alu_res,
   input  logic [DATA_W-1:0] addr_base,
   input  logic [DATA_W-1:0] addr_disp,
   output logic [DATA_W-1:0] addr_sum,
   output logic              flag_zf,
   output logic              flag_sf,
   output logic              flag_of
);
   localparam int MSB = DATA_W - 1;
   localparam logic [STAT_W-1:0] ST_OK = STAT_W'(ST_NORMAL);

   if (ST_NORMAL >= (1 << STAT_W)) begin : g_bad_status
      $error("alu_ccr: ST_NORMAL does not fit in STAT_W bits");
   end

   logic ovf;
   logic fn_ok;
   logic res_zero;
   logic cc_load;
   cc_t  cc_nxt;
   cc_t  cc_cur;

   alu_exec #(.DATA_W(DATA_W)) u_exec (
      .fn    (fn_code),
      .opa   (op_a),
      .opb   (op_b),
      .res   (alu_res),
      .ovf   (ovf),
      .fn_ok (fn_ok)
   );

   alu_zero_det #(.DATA_W(DATA_W), .CHUNK_W(ZD_CHUNK)) u_zdet (
      .val     (alu_res),
      .is_zero (res_zero)
   );

   alu_addr_add #(.DATA_W(DATA_W)) u_agu (
      .base (addr_base),
      .disp (addr_disp),
      .sum  (addr_sum)
   );

   assign cc_load = op_en && (run_status == ST_OK) && fn_ok;
   assign cc_nxt  = '{zf: res_zero, sf: alu_res[MSB], of: ovf};

   alu_cc_reg u_cc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cc_load),
      .nxt   (cc_nxt),
      .cur   (cc_cur)
   );

   assign flag_zf = cc_cur.zf;
   assign flag_sf = cc_cur.sf;
   assign flag_of = cc_cur.of;

   p_zf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cc_load |=> flag_zf == ($past(alu_res) == '0));
   p_sf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cc_load |=> flag_sf == $past(alu_res[MSB]));
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cc_load && (fn_code == FN_AND || fn_code == FN_XOR) |=> !flag_of);
   p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_status != ST_OK |=> $stable({flag_zf, flag_sf, flag_of}));
   p_fn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fn_code > FN_XOR |=> $stable({flag_zf, flag_sf, flag_of}));
endmodule

// File: tb/test_alu_ccr.sv
module test_alu_ccr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_en = 1'b0;
   logic [3:0]  fn_code = '0;
   logic [31:0] op_a = '0, op_b = '0, addr_base = '0, addr_disp = '0;
   logic [2:0]  run_status = 3'd1;
   logic [31:0] alu_res, addr_sum;
   logic        flag_zf, flag_sf, flag_of;

   int checks = 0;
   int fails  = 0;
   logic m_zf = 1'b1, m_sf = 1'b0, m_of = 1'b0;

   always #5 clk = ~clk;

   alu_ccr i_alu_ccr (
      .clk(clk), .rst_n(rst_n), .op_en(op_en), .fn_code(fn_code),
      .op_a(op_a), .op_b(op_b), .run_status(run_status), .alu_res(alu_res),
      .addr_base(addr_base), .addr_disp(addr_disp), .addr_sum(addr_sum),
      .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of)
   );

   function automatic logic [31:0] ref_res(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
      case (f)
         4'd0: return b + a;
         4'd1: return b - a;
         4'd2: return a & b;
         4'd3: return a ^ b;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic ref_of(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] r;
      r = ref_res(f, a, b);
      if (f == 4'd0) return (a[31] == b[31]) && (r[31] != a[31]);
      if (f == 4'd1) return (a[31] != b[31]) && (r[31] != b[31]);
      return 1'b0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string res_tag(input logic [3:0] f);
      if (f == 4'd0) return "R1";
      if (f == 4'd1) return "R2";
      if (f < 4'd4)  return "R3";
      return "R10";
   endfunction

   function automatic string of_tag(input logic [3:0] f);
      if (f == 4'd0) return "R5";
      if (f == 4'd1) return "R6";
      if (f < 4'd4)  return "R3";
      return "R10";
   endfunction

   // drive at falling edge, check comb outputs 1 time unit later, flags at next falling edge
   task automatic do_op(input logic en, input logic [3:0] f, input logic [31:0] a,
                        input logic [31:0] b, input logic [2:0] st,
                        input logic [31:0] ba, input logic [31:0] di);
      logic [31:0] r;
      logic        upd;
      op_en = en; fn_code = f; op_a = a; op_b = b; run_status = st;
      addr_base = ba; addr_disp = di;
      #1;
      r = ref_res(f, a, b);
      chk(res_tag(f), alu_res, r);
      chk("R11", addr_sum, ba + di);
      upd = en && (st == 3'd1) && (f < 4'd4);
      if (upd) begin
         m_zf = (r == 32'd0);
         m_sf = r[31];
         m_of = ref_of(f, a, b);
      end
      @(negedge clk);
      if (!en)              chk("R7", {flag_zf, flag_sf, flag_of}, {m_zf, m_sf, m_of});
      else if (st != 3'd1)  chk("R8", {flag_zf, flag_sf, flag_of}, {m_zf, m_sf, m_of});
      else if (f >= 4'd4)   chk("R10", {flag_zf, flag_sf, flag_of}, {m_zf, m_sf, m_of});
      else begin
         chk("R4", {flag_zf, flag_sf}, {m_zf, m_sf});
         chk(of_tag(f), flag_of, m_of);
      end
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      op_en = 1'b1; fn_code = 4'd0; op_a = 32'h8000_0000; op_b = 32'h8000_0000;
      repeat (3) @(negedge clk);
      chk("R9", {flag_zf, flag_sf, flag_of}, 3'b100);
      rst_n = 1'b1;
      op_en = 1'b0;
      @(negedge clk);
      chk("R9", {flag_zf, flag_sf, flag_of}, 3'b100);

      do_op(1, 4'd0, 32'h0000_0001, 32'h7FFF_FFFF, 1, 32'h1000, 32'hFFFF_FFFC); // R5 pos ovf
      do_op(1, 4'd0, 32'h8000_0000, 32'h8000_0000, 1, 32'h0,    32'h4);         // R5 neg ovf, zero
      do_op(1, 4'd1, 32'h0000_0001, 32'h8000_0000, 1, 32'hFFFF_FFFC, 32'h4);    // R6 ovf
      do_op(1, 4'd1, 32'h1234_5678, 32'h1234_5678, 1, 32'h40,   32'h1C);        // R2 equal -> zero
      do_op(1, 4'd1, 32'h0000_0005, 32'h0000_0003, 1, 32'h0,    32'h0);         // R2 order: 3-5
      do_op(1, 4'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1, 32'h0,    32'h0);         // R6 ovf
      do_op(1, 4'd2, 32'hF0F0_F0F0, 32'h8F0F_0F0F, 1, 32'h0,    32'h0);         // R3 and, neg
      do_op(1, 4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 32'h0,    32'h0);         // set OF again
      do_op(1, 4'd3, 32'hAAAA_5555, 32'hAAAA_5555, 1, 32'h0,    32'h0);         // R3 xor clears OF
      do_op(1, 4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1, 32'h0,    32'h0);         // OF=1 SF=0
      do_op(0, 4'd3, 32'h0,         32'h0,         1, 32'h0,    32'h0);         // R7 hold
      do_op(1, 4'd3, 32'h0,         32'h0,         2, 32'h0,    32'h0);         // R8 halted
      do_op(1, 4'd3, 32'h0,         32'h0,         4, 32'h0,    32'h0);         // R8 bad insn
      do_op(1, 4'd5, 32'h0,         32'h0,         1, 32'h0,    32'h0);         // R10
      do_op(1, 4'd15, 32'hFFFF_FFFF, 32'h1,        1, 32'h2000, 32'hFFFF_FFFC); // R10, R11

      for (int i = 0; i < 400; i++) begin
         logic [3:0] f;
         logic       en;
         logic [2:0] st;
         f  = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 4);
         en = ($urandom % 6) != 0;
         st = ($urandom % 6 == 0) ? 3'($urandom) : 3'd1;
         do_op(en, f, $urandom, $urandom, st, $urandom, $urandom);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule